// File: doc/BRIEF.md
# Loadable Long-Code Chip Scrambler

This block scrambles a stream of already spread information chips with a long pseudo-random code, so that the spectrum and autocorrelation of the transmitted Q branch no longer reflect the weak correlation properties of orthogonal spreading codes. The code comes from a 24-bit linear feedback shift register. A host programs both the feedback taps and the starting state through a small write-only register port, so the same hardware can follow any code plan chosen at run time.

Each asserted chip enable marks one chip boundary. The Q chip presented in that cycle leaves XORed with the current code bit. The I branch (synchronisation chips) passes through unchanged, so that both branches can be merged downstream into a single modulator stream. The receiver runs an identical copy with the same taps and seed, and recovers the original chips with the same XOR.

Top module: `long_code_scrambler`

## Requirements
- R1: After reset the scrambler is stopped, the tap word is the parameter `RST_TAPS` (default 24'hE10000) and the start state is 24'h000001, so `q_out` equals `q_chip`.
- R2: `i_out` always equals `i_chip` in the same cycle, whatever the run state.
- R3: While stopped (control bit 0 = 0), `q_out` equals `q_chip` and chip enables do not advance the code register.
- R4: While running, `q_out` = `q_chip` XOR the code bit, which is bit 23 of the current code state. The output is combinational within the chip's cycle.
- R5: On each chip enable while running, the code state shifts one place toward bit 23. The new bit 0 is the XOR of all bits of (state AND tap word).
- R6: A write to address 1 stores a new seed, and the state is left untouched until the next chip enable. The chip in that boundary cycle is scrambled with bit 23 of the new seed, and the state steps from the seed.
- R7: A write to address 2 with bit 1 set (restart) reloads the stored seed at the next chip enable, with the same timing as R6.
- R8: A seed of zero is replaced by 24'h000001 when it is loaded.
- R9: A write to address 0 replaces the tap word and affects the feedback from the next step on. Writes to address 3 change nothing.
- R10: A second instance with the same taps and seed, fed the scrambled chips, reproduces the original chips exactly.
- R11: Clearing the run bit freezes the state. Setting it again continues the sequence from the frozen state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 taps, 1 seed, 2 control (bit0 run, bit1 restart) |
| wr_data | input | 24 | Write data |
| chip_en | input | 1 | One-cycle pulse per chip boundary |
| i_chip | input | 1 | Incoming sync-branch chip |
| q_chip | input | 1 | Incoming spread information chip |
| i_out | output | 1 | Sync chip out, unchanged |
| q_out | output | 1 | Scrambled information chip |

## Verification
`q_out` and `i_out` follow their inputs in the same cycle. The bench therefore drives each chip just after a falling edge and compares one time unit later, before the rising edge that consumes it. A register write, a seed load or a step becomes visible only at the chip after the rising edge that took it. The bench's model updates its copy of the state at that same edge, so every comparison uses the code bit the design must show at that moment. The round-trip test replays captured outputs into the design after a restart, and each chip is compared in the cycle it is driven.

// File: rtl/long_code_scrambler.sv
module long_code_scrambler #(
  parameter int         W        = 24,
  parameter logic [W-1:0] RST_TAPS = 24'hE10000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         chip_en,
  input  logic         i_chip,
  input  logic         q_chip,
  output logic         i_out,
  output logic         q_out
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] taps, seed, state, cur, nxt;
  logic         run, pend;

  wire seed_wr    = wr_en && wr_addr == 2'd1;
  wire ctrl_wr    = wr_en && wr_addr == 2'd2;
  wire restart_wr = ctrl_wr && wr_data[1];

  assign cur   = pend ? seed : state;
  assign nxt   = {cur[W-2:0], ^(cur & taps)};
  assign i_out = i_chip;
  assign q_out = q_chip ^ (run & cur[W-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taps  <= RST_TAPS;
      seed  <= ONE;
      state <= ONE;
      run   <= 1'b0;
      pend  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == 2'd0) taps <= wr_data;
      if (seed_wr) seed <= (wr_data == '0) ? ONE : wr_data;
      if (ctrl_wr) run <= wr_data[0];
      if (chip_en) begin
        state <= run ? nxt : cur;
        pend  <= 1'b0;
      end
      if (seed_wr || restart_wr) pend <= 1'b1;
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pend && chip_en) |=> $stable(state));

  // R5
  shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pend && chip_en) |=> state[W-1:1] == $past(state[W-2:0]));

  // R6
  no_early_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en) |=> $stable(state));

  // R6
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && chip_en && !seed_wr && !restart_wr) |=> !pend);

  // R8
  nonzero_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && chip_en && !run) |=> state != '0);

endmodule

// File: tb/sim_long_code_scrambler.sv
module sim_long_code_scrambler;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, chip_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic i_chip = 1'b0, q_chip = 1'b0;
  logic i_out, q_out;

  int n_cmp = 0, n_bad = 0;
  logic [23:0] m_state, m_taps, m_seed;
  logic m_run, m_pend;
  logic [23:0] stim = 24'h5A3C1F;
  logic cap [0:63];
  logic orig [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  long_code_scrambler u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .chip_en(chip_en), .i_chip(i_chip), .q_chip(q_chip),
    .i_out(i_out), .q_out(q_out));

  task automatic check(input bit ok, input string tag, input logic act, input logic exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] cur_m();
    return m_pend ? m_seed : m_state;
  endfunction

  task automatic bus_write(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    case (a)
      2'd0: m_taps = d;
      2'd1: begin m_seed = (d == 0) ? 24'h1 : d; m_pend = 1'b1; end
      2'd2: begin m_run = d[0]; if (d[1]) m_pend = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic next_stim();
    stim = {stim[22:0], stim[23] ^ stim[22] ^ stim[21] ^ stim[16]};
  endtask

  task automatic chip(input logic iv, input logic qv, input string tag, output logic qo);
    logic [23:0] c;
    logic exp;
    @(negedge clk);
    chip_en = 1'b1; i_chip = iv; q_chip = qv;
    #1;
    c = cur_m();
    exp = qv ^ (m_run & c[23]);
    check(i_out === iv, "R2 i pass", i_out, iv);
    check(q_out === exp, tag, q_out, exp);
    qo = q_out;
    @(posedge clk); #1;
    chip_en = 1'b0;
    m_state = m_run ? {c[22:0], ^(c & m_taps)} : c;
    m_pend = 1'b0;
  endtask

  task automatic run_chips(input int n, input string tag);
    logic qo;
    for (int k = 0; k < n; k++) begin
      next_stim();
      chip(stim[3], stim[0], tag, qo);
    end
  endtask

  task automatic t_reset();
    logic qo;
    chip(1'b1, 1'b1, "R1 reset passthrough", qo);
    chip(1'b0, 1'b0, "R1 reset passthrough", qo);
  endtask

  task automatic t_idle();
    run_chips(10, "R3 stopped passthrough");
    bus_write(2'd2, 24'h1);
    run_chips(30, "R3 R5 sequence from reset state");
  endtask

  task automatic t_seed();
    bus_write(2'd1, 24'hC3A5F0);
    repeat (3) @(negedge clk);
    run_chips(100, "R4 R5 R6 scramble after seed load");
  endtask

  task automatic t_zero_seed();
    bus_write(2'd1, 24'h0);
    run_chips(40, "R8 zero seed forced to one");
  endtask

  task automatic t_restart();
    bus_write(2'd1, 24'h80F00D);
    run_chips(20, "R7 pre-restart");
    bus_write(2'd2, 24'h3);
    run_chips(30, "R7 restart replays seed");
  endtask

  task automatic t_taps();
    bus_write(2'd0, 24'h8A0013);
    run_chips(40, "R9 new taps");
    bus_write(2'd3, 24'hFFFFFF);
    run_chips(30, "R9 address 3 ignored");
  endtask

  task automatic t_round_trip();
    logic qo;
    bus_write(2'd1, 24'h2468AC);
    bus_write(2'd2, 24'h1);
    for (int k = 0; k < 64; k++) begin
      next_stim();
      orig[k] = stim[5];
      chip(stim[1], orig[k], "R10 scramble pass", qo);
      cap[k] = qo;
    end
    bus_write(2'd2, 24'h3);
    for (int k = 0; k < 64; k++) begin
      chip(1'b0, cap[k], "R10 descramble pass", qo);
      check(qo === orig[k], "R10 round trip", qo, orig[k]);
    end
  endtask

  task automatic t_pause();
    run_chips(15, "R11 before pause");
    bus_write(2'd2, 24'h0);
    run_chips(12, "R11 paused passthrough");
    bus_write(2'd2, 24'h1);
    run_chips(25, "R11 resumes from frozen state");
  endtask

  initial begin
    m_state = 24'h1; m_seed = 24'h1; m_taps = 24'hE10000; m_run = 1'b0; m_pend = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_idle();
    t_seed();
    t_zero_seed();
    t_restart();
    t_taps();
    t_round_trip();
    t_pause();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule